// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps every row of one DRAM bank charged. It counts clock cycles to find the retention period and the per-row interval. It keeps a pointer to the next row due, and it turns each row refresh into an activate command followed by a precharge command on that row. Two policies are available. In distributed mode, one row is refreshed each time an interval elapses, so the rows are spread evenly over the period. In burst mode, all rows are refreshed back to back at the start of a period, and nothing more is refreshed until the next period starts.

The block raises a request whenever it has refresh work pending. It waits for the bank's access logic to return a grant, which that logic gives once its current access has finished. From the activate command until precharge recovery ends, the block drives a busy output that keeps normal traffic away from the bank. The policy input is sampled only when a period ends, so a period is always served by one policy from start to finish. A sticky overdue flag records any interval or period that ended while refresh work was still waiting.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, refReq, refBusy, actValid, preValid and overdue are 0, modeNow is 0 (distributed), and cmdRow is 0.
- R2: Each refresh issues an activate (actValid for one cycle) and then a precharge (preValid for one cycle) exactly T_RAS cycles later, and cmdRow holds the same row for both.
- R3: refBusy is 1 from the activate cycle through the T_RP-1 cycles after the precharge, and 0 in the cycle T_RP after the precharge. The next activate comes at least T_RP+1 cycles after a precharge.
- R4: An activate is issued only in the cycle after refReq and refGrant were both 1. refReq stays 1 until grant arrives, and no activate is issued while refGrant is held at 0.
- R5: The row pointer starts at 0, advances by one after each refresh, and wraps from ROWS-1 to 0. Rows are refreshed strictly in that order.
- R6: In distributed mode (modeSel=0), with grant always given, successive activates are exactly INTERVAL = PERIOD_CLKS/ROWS cycles apart.
- R7: In burst mode (modeSel=1), ROWS refreshes run back to back at the start of the period, with activates T_RAS+T_RP+1 cycles apart when grant is always given. No further activate follows until the next period.
- R8: modeSel is sampled only at period boundaries, which fall every PERIOD_CLKS cycles after reset. modeNow shows the policy in force and changes only at a boundary. The first period after reset is distributed.
- R9: overdue is set when an interval (distributed) or a period boundary arrives while refresh work from before is still outstanding. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 1 | Requested policy: 1 burst, 0 distributed |
| refGrant | input | 1 | Bank idle and handed over to refresh |
| refReq | output | 1 | Refresh work waiting for a grant |
| refBusy | output | 1 | Bank unavailable to normal accesses |
| actValid | output | 1 | Activate command strobe |
| preValid | output | 1 | Precharge command strobe |
| cmdRow | output | ROW_W | Row addressed by activate and precharge |
| modeNow | output | 1 | Policy in force this period: 1 burst |
| overdue | output | 1 | Sticky flag: refresh work missed its deadline |

## Verification
A row pointer that skips or repeats a value shows up at the very next activate, because cmdRow no longer matches the row sequence the scoreboard expects. A broken interval or period counter changes the spacing between activates within one interval, or moves the policy switch away from the PERIOD_CLKS boundary. A timer that loads the wrong value moves the precharge or the release of busy by a cycle inside the same refresh. Losing the pending-work count in burst mode changes how many activates appear in one period, and this is visible before the next boundary.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACT,
    ST_RAS,
    ST_PRE,
    ST_RP
  } rfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic act;
    logic pre;
  } rfStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic owedNz;
    logic timerZero;
  } rfStat_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int ROWS        = 16384,
  parameter int PERIOD_CLKS = 6400000,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 4,
  parameter int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  rfStrb_t          strb,
  output rfStat_t          stat,
  output logic [ROW_W-1:0] cmdRow,
  output logic             modeNow,
  output logic             overdue
);

  localparam int INTERVAL = PERIOD_CLKS / ROWS;
  localparam int PER_W    = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam int INT_W    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int OW_W     = $clog2(ROWS + 1);
  localparam int TMAX     = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMR_W    = $clog2(TMAX) + 1;

  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CLKS - 1);
  localparam logic [INT_W-1:0] INT_LAST = INT_W'(INTERVAL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [OW_W-1:0]  OW_ALL   = OW_W'(ROWS);
  localparam logic [TMR_W-1:0] RAS_LD   = TMR_W'(T_RAS - 2);
  localparam logic [TMR_W-1:0] RP_LD    = TMR_W'(T_RP - 2);

  logic [PER_W-1:0] periodCnt;
  logic [INT_W-1:0] intCnt;
  logic [OW_W-1:0]  owed;
  logic [OW_W-1:0]  owedAfter;
  logic [ROW_W-1:0] rowPtr;
  logic [TMR_W-1:0] timer;
  logic             periodTick;
  logic             intTick;

  assign periodTick = (periodCnt == PER_LAST);
  assign intTick    = (intCnt == INT_LAST);
  assign owedAfter  = owed - OW_W'(strb.act);

  // period and interval counters; interval realigns to each period start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      intCnt    <= '0;
    end else begin
      periodCnt <= periodTick ? '0 : periodCnt + PER_W'(1);
      intCnt    <= (periodTick || intTick) ? '0 : intCnt + INT_W'(1);
    end
  end

  // outstanding row count, policy latch and deadline flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owed    <= '0;
      modeNow <= 1'b0;
      overdue <= 1'b0;
    end else if (periodTick) begin
      modeNow <= modeSel;
      owed    <= modeSel ? OW_ALL : OW_W'(1);
      if (owedAfter != '0) overdue <= 1'b1;
    end else if (intTick && !modeNow) begin
      owed <= OW_W'(1);
      if (owedAfter != '0) overdue <= 1'b1;
    end else begin
      owed <= owedAfter;
    end
  end

  // row pointer advances once the precharge of its row is issued
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowPtr <= '0;
    end else if (strb.pre) begin
      rowPtr <= (rowPtr == ROW_LAST) ? '0 : rowPtr + ROW_W'(1);
    end
  end

  // shared gap timer for activate-to-precharge and precharge recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.act) begin
      timer <= RAS_LD;
    end else if (strb.pre) begin
      timer <= RP_LD;
    end else if (timer != '0) begin
      timer <= timer - TMR_W'(1);
    end
  end

  assign stat.owedNz    = (owed != '0);
  assign stat.timerZero = (timer == '0);
  assign cmdRow         = rowPtr;

  AST_ROW_MOVES_ON_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (rowPtr != $past(rowPtr)) |-> $past(strb.pre)); // R5
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pre && rowPtr == ROW_LAST) |=> (rowPtr == '0)); // R5
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow != $past(modeNow)) |-> $past(periodTick)); // R8
  AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(overdue) |-> overdue); // R9
  AST_ACT_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |-> (owed != '0)); // R7

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refGrant,
  input  rfStat_t stat,
  output rfStrb_t strb,
  output logic    refReq,
  output logic    refBusy
);

  rfState_e state;
  rfState_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (stat.owedNz) stateNxt = ST_REQ;
      ST_REQ:  if (refGrant) stateNxt = ST_ACT;
      ST_ACT:  stateNxt = ST_RAS;
      ST_RAS:  if (stat.timerZero) stateNxt = ST_PRE;
      ST_PRE:  stateNxt = ST_RP;
      ST_RP:   if (stat.timerZero) stateNxt = stat.owedNz ? ST_REQ : ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign strb.act = (state == ST_ACT);
  assign strb.pre = (state == ST_PRE);
  assign refReq   = (state == ST_REQ);
  assign refBusy  = (state == ST_ACT) || (state == ST_RAS) ||
                    (state == ST_PRE) || (state == ST_RP);

  AST_ACT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |-> $past(refReq && refGrant)); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> refReq); // R4
  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.act || strb.pre) |-> refBusy); // R3
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.act && strb.pre)); // R2
  AST_PRE_FOLLOWS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.pre |-> $past(state == ST_RAS)); // R2

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int ROWS        = 16384,
  parameter int PERIOD_CLKS = 6400000,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 4,
  parameter int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             refGrant,
  output logic             refReq,
  output logic             refBusy,
  output logic             actValid,
  output logic             preValid,
  output logic [ROW_W-1:0] cmdRow,
  output logic             modeNow,
  output logic             overdue
);

  rfStrb_t strb;
  rfStat_t stat;

  refsched_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .stat     (stat),
    .strb     (strb),
    .refReq   (refReq),
    .refBusy  (refBusy)
  );

  refsched_dp #(
    .ROWS        (ROWS),
    .PERIOD_CLKS (PERIOD_CLKS),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP),
    .ROW_W       (ROW_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .strb    (strb),
    .stat    (stat),
    .cmdRow  (cmdRow),
    .modeNow (modeNow),
    .overdue (overdue)
  );

  assign actValid = strb.act;
  assign preValid = strb.pre;

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;

  localparam int ROWS = 8;
  localparam int PER  = 160;
  localparam int TRAS = 3;
  localparam int TRP  = 2;
  localparam int INTV = PER / ROWS;
  localparam int BGAP = TRAS + TRP + 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0;
  logic       refGrant = 1'b0;
  logic       refReq, refBusy, actValid, preValid, modeNow, overdue;
  logic [2:0] cmdRow;

  refresh_sched #(.ROWS(ROWS), .PERIOD_CLKS(PER), .T_RAS(TRAS), .T_RP(TRP)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .refGrant(refGrant),
    .refReq(refReq), .refBusy(refBusy), .actValid(actValid), .preValid(preValid),
    .cmdRow(cmdRow), .modeNow(modeNow), .overdue(overdue)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expRows[$];
  int nextPush = 0;
  int actCount = 0;
  int expGap = 0;
  int skipN = 1;
  int lastAct = -1000;
  int lastPre = -1000;
  int lastRow = 0;
  int popped;
  bit done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected row order with wrap (R5)
  task automatic pushRows(int n);
    for (int i = 0; i < n; i++) begin
      expRows.push_back(nextPush);
      nextPush = (nextPush + 1) % ROWS;
    end
  endtask

  task automatic waitActs(int target, int limit);
    for (int i = 0; i < limit && actCount < target; i++) @(negedge clk);
  endtask

  // monitor: pops expected rows and checks command timing
  always @(negedge clk) begin
    if (rstN) begin
      if (actValid) begin
        if (expRows.size() == 0) chk(1'b0, "R5 scoreboard empty", int'(cmdRow), -1);
        else begin
          popped = expRows.pop_front();
          chk(int'(cmdRow) == popped, "R5 activate row order", int'(cmdRow), popped);
        end
        chk(refBusy == 1'b1, "R3 busy at activate", int'(refBusy), 1);
        chk(cyc - lastPre >= TRP + 1, "R3 precharge to activate gap", cyc - lastPre, TRP + 1);
        if (skipN > 0) skipN--;
        else if (expGap == INTV) chk(cyc - lastAct == INTV, "R6 distributed spacing", cyc - lastAct, INTV);
        else if (expGap == BGAP) chk(cyc - lastAct == BGAP, "R7 burst spacing", cyc - lastAct, BGAP);
        lastAct = cyc;
        lastRow = int'(cmdRow);
        actCount++;
      end
      if (preValid) begin
        chk(cyc - lastAct == TRAS, "R2 activate to precharge", cyc - lastAct, TRAS);
        chk(int'(cmdRow) == lastRow, "R2 precharge row", int'(cmdRow), lastRow);
        chk(refBusy == 1'b1, "R3 busy at precharge", int'(refBusy), 1);
        lastPre = cyc;
      end
      if (cyc == lastPre + TRP - 1 && !preValid)
        chk(refBusy == 1'b1, "R3 busy in recovery", int'(refBusy), 1);
      if (cyc == lastPre + TRP)
        chk(refBusy == 1'b0, "R3 busy released", int'(refBusy), 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, a0, m1, w;
    pushRows(400);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(refReq == 1'b0,   "R1 refReq in reset", int'(refReq), 0);
    chk(refBusy == 1'b0,  "R1 refBusy in reset", int'(refBusy), 0);
    chk(actValid == 1'b0, "R1 actValid in reset", int'(actValid), 0);
    chk(preValid == 1'b0, "R1 preValid in reset", int'(preValid), 0);
    chk(overdue == 1'b0,  "R1 overdue in reset", int'(overdue), 0);
    chk(modeNow == 1'b0,  "R1 modeNow in reset", int'(modeNow), 0);
    chk(cmdRow == 3'd0,   "R1 cmdRow in reset", int'(cmdRow), 0);
    modeSel  = 1'b1;   // must be ignored for the first period (R8)
    rstN     = 1'b1;
    refGrant = 1'b1;
    expGap   = INTV;
    skipN    = 1;
    @(negedge clk);
    modeSel = 1'b0;

    // distributed refreshes across a period boundary (R6, R5, R8)
    waitActs(10, 600);
    chk(actCount >= 10, "R6 distributed refreshes issued", actCount, 10);
    chk(modeNow == 1'b0, "R8 first period distributed", int'(modeNow), 0);

    // withheld grant (R4)
    refGrant = 1'b0;
    @(negedge clk);
    c0 = actCount;
    w = 0;
    while (!refReq && w < INTV + 5) begin @(negedge clk); w++; end
    chk(refReq == 1'b1, "R4 request raised", int'(refReq), 1);
    repeat (10) @(negedge clk);
    chk(refReq == 1'b1, "R4 request held", int'(refReq), 1);
    chk(refBusy == 1'b0, "R4 not busy before grant", int'(refBusy), 0);
    chk(actCount == c0, "R4 no activate without grant", actCount, c0);
    chk(overdue == 1'b0, "R9 clear when served in time", int'(overdue), 0);
    skipN = 2;
    refGrant = 1'b1;
    @(negedge clk);
    chk(actValid == 1'b1, "R4 activate after grant", int'(actValid), 1);
    waitActs(c0 + 3, 200);

    // switch to burst at the next boundary (R8, R7)
    while (!actValid) @(negedge clk);
    modeSel = 1'b1;
    @(negedge clk);
    chk(modeNow == 1'b0, "R8 mode held before boundary", int'(modeNow), 0);
    w = 0;
    while (!modeNow && w < PER + 5) begin @(negedge clk); w++; end
    chk(modeNow == 1'b1, "R8 burst taken at boundary", int'(modeNow), 1);
    m1 = cyc;
    expGap = BGAP;
    skipN = 1;
    modeSel = 1'b0;
    a0 = actCount;
    repeat (PER - 2) @(negedge clk);
    chk(actCount - a0 == ROWS, "R7 one burst of all rows per period", actCount - a0, ROWS);
    chk(modeNow == 1'b1, "R8 mode held mid-period", int'(modeNow), 1);
    w = 0;
    while (modeNow && w < 10) begin @(negedge clk); w++; end
    chk(cyc - m1 == PER, "R8 boundary spacing", cyc - m1, PER);
    expGap = INTV;
    skipN = 1;
    waitActs(a0 + ROWS + 3, 400);
    chk(actCount == a0 + ROWS + 3, "R6 distributed after burst", actCount, a0 + ROWS + 3);

    // missed deadline (R9)
    while (!actValid) @(negedge clk);
    refGrant = 1'b0;
    @(negedge clk);
    c0 = actCount;
    repeat (2 * INTV + 5) @(negedge clk);
    chk(overdue == 1'b1, "R9 overdue set", int'(overdue), 1);
    chk(actCount == c0, "R4 still no activate", actCount, c0);
    skipN = 2;
    refGrant = 1'b1;
    waitActs(c0 + 1, 20);
    repeat (3) @(negedge clk);
    chk(overdue == 1'b1, "R9 overdue sticky", int'(overdue), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule